// File: doc/BRIEF.md
# Bus-Attached Shift Register with Preset

This block is a small storage register, one D flip-flop per bit, meant to hang on a shared data bus. In a single clock edge it can take a word from the bus, fill itself with ones, or move its contents by one place. When it moves, a new bit comes in from a serial pin and the top stage leaves on a serial output pin. A separate read control decides whether the stored word is placed on the bus outputs. When the read control is low, those outputs float, so several registers can share the same wires.

On each edge the block picks exactly one operation. The operations are HOLD, PRESET, LOAD and SHIFT. The choice goes through a fixed priority: reset first, then preset-with-write, then write, then shift. If none of these applies, the register holds. A synchronous active-low reset clears the stored word. The serial output shows the highest stage at all times, whatever the read control is doing.

Top module: `busreg_sp`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, the stored word becomes all zeros.
- R2: With `wr_en` high and `preset` low, the stored word takes the value of `par_in` at the edge.
- R3: With `wr_en` and `preset` both high, every stored bit becomes 1. This happens whatever `par_in` and `shift_en` are.
- R4: `preset` alone, without `wr_en`, has no effect. With `shift_en` also low, the register holds.
- R5: With `shift_en` high and `wr_en` low, bit i takes the old bit i-1 and bit 0 takes `ser_in`.
- R6: `ser_out` always equals stored bit W-1. A bit entered on `ser_in` appears on `ser_out` after W shift edges, and not before.
- R7: When `wr_en` and `shift_en` are both high, the write (LOAD or PRESET) wins and no shift takes place.
- R8: With `wr_en` and `shift_en` both low, the stored word does not change.
- R9: With `rd_en` high, `bus_q` shows the stored word (bit i = stage i). With `rd_en` low, every bit of `bus_q` is high impedance. `rd_en` never changes the stored word.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low clear |
| wr_en | input | 1 | Parallel write enable |
| shift_en | input | 1 | Serial shift enable |
| preset | input | 1 | Fill with ones; acts only together with `wr_en` |
| rd_en | input | 1 | Drive the stored word onto `bus_q` |
| par_in | input | W (4) | Parallel data taken from the bus |
| ser_in | input | 1 | Serial data into stage 0 |
| bus_q | output | W (4) | Stored word when reading, otherwise high impedance |
| ser_out | output | 1 | Stage W-1 |

## Verification
The commands can collide in one edge. A write and a shift can both be asked for, and the preset can arrive with or without the write. The bench provokes these cases by sweeping all sixteen combinations of the four controls against every data word. The expected next word is computed from the priority order, and the result is judged after each edge. It is read back on the bus when reading is enabled. In the next cycle, it is read with reading switched on, so a lost or wrongly ranked command shows up.

// File: rtl/busreg_pkg.sv
package busreg_pkg;
    typedef enum logic [1:0] {
        OP_HOLD   = 2'd0,
        OP_PRESET = 2'd1,
        OP_LOAD   = 2'd2,
        OP_SHIFT  = 2'd3
    } op_e;
endpackage

// File: rtl/busreg_opsel.sv
module busreg_opsel
    import busreg_pkg::*;
(
    input  logic wr_en,
    input  logic shift_en,
    input  logic preset,
    output op_e  op
);
    always_comb begin
        unique case ({wr_en, preset, shift_en})
            3'b110, 3'b111: op = OP_PRESET;
            3'b100, 3'b101: op = OP_LOAD;
            3'b001, 3'b011: op = OP_SHIFT;
            default:        op = OP_HOLD;
        endcase
    end
endmodule

// File: rtl/busreg_cell.sv
module busreg_cell
    import busreg_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  op_e  op,
    input  logic par_bit,
    input  logic prev_bit,
    output logic q
);
    logic d;

    always_comb begin
        unique case (op)
            OP_PRESET: d = 1'b1;
            OP_LOAD:   d = par_bit;
            OP_SHIFT:  d = prev_bit;
            default:   d = q;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= 1'b0;
        else        q <= d;
    end
endmodule

// File: rtl/busreg_sp.sv
module busreg_sp
    import busreg_pkg::*;
#(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_en,
    input  logic         shift_en,
    input  logic         preset,
    input  logic         rd_en,
    input  logic [W-1:0] par_in,
    input  logic         ser_in,
    output logic [W-1:0] bus_q,
    output logic         ser_out
);
    localparam int LAST = W - 1;

    op_e          op;
    logic [W-1:0] q_r;
    logic [W-1:0] feed;

    busreg_opsel u_opsel (
        .wr_en    (wr_en),
        .shift_en (shift_en),
        .preset   (preset),
        .op       (op)
    );

    assign feed = {q_r[W-2:0], ser_in};

    for (genvar i = 0; i < W; i++) begin : g_bit
        busreg_cell u_cell (
            .clk      (clk),
            .rst_n    (rst_n),
            .op       (op),
            .par_bit  (par_in[i]),
            .prev_bit (feed[i]),
            .q        (q_r[i])
        );
    end

    assign ser_out = q_r[LAST];
    assign bus_q   = rd_en ? q_r : {W{1'bz}};
endmodule

// File: rtl/busreg_chk.sv
module busreg_chk #(
    parameter int W = 4
) (
    input logic         clk,
    input logic         rst_n,
    input logic         wr_en,
    input logic         shift_en,
    input logic         preset,
    input logic [W-1:0] par_in,
    input logic         ser_in,
    input logic [W-1:0] q
);
    // R1
    a_r1_clear: assert property (@(posedge clk) !rst_n |=> q == '0);
    // R2
    a_r2_load: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !preset) |=> q == $past(par_in));
    // R3
    a_r3_preset: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && preset) |=> q == '1);
    // R4
    a_r4_lone_preset: assert property (@(posedge clk) disable iff (!rst_n)
        (preset && !wr_en && !shift_en) |=> $stable(q));
    // R5
    a_r5_shift: assert property (@(posedge clk) disable iff (!rst_n)
        (shift_en && !wr_en) |=> q == {$past(q[W-2:0]), $past(ser_in)});
    // R7
    a_r7_write_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (shift_en && wr_en && !preset) |=> q == $past(par_in));
    // R8
    a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en && !shift_en) |=> $stable(q));
endmodule

bind busreg_sp busreg_chk #(.W(W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .shift_en (shift_en),
    .preset   (preset),
    .par_in   (par_in),
    .ser_in   (ser_in),
    .q        (q_r)
);

// File: tb/busreg_sp_tb.sv
module busreg_sp_tb;
    localparam int W = 4;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         wr_en = 1'b0, shift_en = 1'b0, preset = 1'b0, rd_en = 1'b0;
    logic [W-1:0] par_in = '0;
    logic         ser_in = 1'b0;
    wire  [W-1:0] bus_q;
    wire          ser_out;

    int n_vec = 0;
    int n_bad = 0;
    logic [W-1:0] model = '0;

    always #10 clk = ~clk;

    busreg_sp #(.W(W)) u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .shift_en(shift_en),
        .preset(preset), .rd_en(rd_en), .par_in(par_in), .ser_in(ser_in),
        .bus_q(bus_q), .ser_out(ser_out)
    );

    task automatic check(input string req, input logic [W-1:0] got, input logic [W-1:0] exp);
        n_vec++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %b expected %b", req, got, exp);
        end
    endtask

    // one edge: drive at negedge, update model, sample 2 ns after the edge
    task automatic step(input logic we, input logic se, input logic pr, input logic re,
                        input logic [W-1:0] d, input logic si);
        @(negedge clk);
        wr_en = we; shift_en = se; preset = pr; rd_en = re; par_in = d; ser_in = si;
        @(posedge clk);
        if (we && pr)  model = '1;
        else if (we)   model = d;
        else if (se)   model = W'((model << 1) | W'(si));
        #2;
    endtask

    task automatic observe(input string req);
        if (rd_en) check(req, bus_q, model);
        else       check({req, " R9 float"}, bus_q, {W{1'bz}});
        check({req, " R6 serial"}, {{(W-1){1'b0}}, ser_out}, {{(W-1){1'b0}}, model[W-1]});
    endtask

    initial begin
        #150000;
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        // R1: reset after a preset clears the word
        rst_n = 1'b1;
        step(1, 0, 1, 1, '0, 0);
        @(negedge clk); rst_n = 1'b0; rd_en = 1'b1; wr_en = 1'b0; preset = 1'b0;
        @(posedge clk); #2;
        model = '0;
        check("R1 reset", bus_q, '0);
        @(negedge clk); rst_n = 1'b1;

        // R2/R3/R4/R5/R7/R8/R9: full sweep of controls against every data word
        for (int c = 0; c < 16; c++) begin
            for (int d = 0; d < 16; d++) begin
                logic we, se, pr, re;
                string tag;
                {we, se, pr, re} = c[3:0];
                if (we && pr)       tag = "R3 preset";
                else if (we && se)  tag = "R7 write beats shift";
                else if (we)        tag = "R2 load";
                else if (se)        tag = "R5 shift";
                else if (pr)        tag = "R4 lone preset";
                else                tag = "R8 hold";
                step(we, se, pr, re, W'(d), d[0] ^ d[2]);
                observe(tag);
                // read back with no command to expose the stored word
                step(0, 0, 0, 1, ~W'(d), 1);
                observe({tag, " readback R9"});
            end
        end

        // R6: a one travels to ser_out in exactly W shifts
        step(1, 0, 0, 0, '0, 0);
        step(0, 1, 0, 0, '0, 1);
        for (int k = 1; k < W; k++) begin
            check("R6 early", {{(W-1){1'b0}}, ser_out}, '0);
            step(0, 1, 0, 0, '1, 0);
        end
        check("R6 arrival", {{(W-1){1'b0}}, ser_out}, {{(W-1){1'b0}}, 1'b1});

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule